// File: doc/BRIEF.md
# Two-Wire Toggle Escape Detector

This block monitors a two-wire debug link that has a link clock and one bidirectional data line. Both inputs are oversampled by a fast system clock. While the link clock is high, the block counts how often the data line changes level. On the next rising edge of the link clock, it turns that count into a control event and then clears the count for the next high phase.

Exactly six toggles start the activation phase. The block pulses `activateStart`, sets the mode register to activating and loads the expected command length of twelve. Eight or more toggles force the link back to plain four-wire operation. The block then pulses `fourWireForce`, returns the mode register to four-wire and clears the command length. Any other count leaves the link as it is. Decoding the activation payload and carrying out scan transfers are handled by later stages, which use the pulse outputs and `expectLen`.

Top module: `escape_detector`

## Requirements
- R1: After reset, `linkMode` is 0 (four-wire), `expectLen` is 0, and both pulse outputs are low.
- R2: Exactly six data-line toggles during one high phase of the link clock, followed by a link-clock rise, produce one `activateStart` pulse. They also set `linkMode` to 1 (activating) and `expectLen` to 12. This holds even when the link is already activating.
- R3: Eight or more toggles followed by a rise produce one `fourWireForce` pulse and set `linkMode` to 0 and `expectLen` to 0. This holds even when the link is already in four-wire mode.
- R4: Toggle counts of 0 to 5, and a count of 7, produce no pulse and leave `linkMode` and `expectLen` unchanged.
- R5: Data-line toggles made while the link clock is low are not counted.
- R6: The toggle count is cleared at every link-clock rise, so toggles from separate high phases never add together.
- R7: The toggle count saturates at 15. A run of 22 toggles therefore forces four-wire mode and does not wrap around to an activation count.
- R8: Each pulse is high for exactly one system-clock cycle per link-clock rise, and the two pulses are never high together.
- R9: With the default two synchronizer stages, a pulse is high in the third system-clock cycle after the link-clock rise reaches the input pin, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rstN | input | 1 | Active-low synchronous reset |
| linkClk | input | 1 | Link clock, asynchronous to `clk` |
| linkData | input | 1 | Data line level, asynchronous to `clk` |
| activateStart | output | 1 | One-cycle pulse when the activation phase begins |
| fourWireForce | output | 1 | One-cycle pulse when four-wire mode is forced |
| linkMode | output | 1 | Mode register: 0 four-wire, 1 activating |
| expectLen | output | 6 | Expected activation command length (12 while activating, else 0) |

## Verification
A wrong toggle count inside the block only becomes visible at the next link-clock rise. It then shows up as a missing, extra or wrong-kind pulse, together with a wrong `linkMode` and `expectLen`, exactly three system cycles after that rise. The checks therefore probe counts on both sides of each threshold and accumulation across phases. They also probe toggles made while the clock is low and counts past the counter's width, because a fault in each case gives a different pulse pattern. A separate cycle-exact check pins the synchronizer depth and the pulse width.

// File: rtl/escape_pkg.sv
package escape_pkg;

  typedef enum logic {
    MODE_FOUR_WIRE  = 1'b0,
    MODE_ACTIVATING = 1'b1
  } linkMode_e;

  typedef struct packed {
    logic clearCount;
    logic countEn;
  } dpStrobe_t;

endpackage

// File: rtl/escape_sync.sv
module escape_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/escape_datapath.sv
module escape_datapath
  import escape_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linkClk,
  input  logic             linkData,
  input  dpStrobe_t        strobe,
  output logic             clkLevel,
  output logic             clkRise,
  output logic [CNT_W-1:0] toggleCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0] syncVal;
  logic       clkPrev, dataPrev;
  logic       dataToggle;

  escape_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({linkData, linkClk}),
    .syncOut (syncVal)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      dataPrev <= 1'b0;
    end else begin
      clkPrev  <= syncVal[0];
      dataPrev <= syncVal[1];
    end
  end

  assign clkLevel   = syncVal[0];
  assign clkRise    = syncVal[0] & ~clkPrev;
  assign dataToggle = syncVal[1] ^ dataPrev;

  always_ff @(posedge clk) begin
    if (!rstN)                       toggleCount <= '0;
    else if (strobe.clearCount)      toggleCount <= '0;
    else if (strobe.countEn && dataToggle && toggleCount != CNT_MAX)
                                     toggleCount <= toggleCount + 1'b1;
  end

  // R6
  count_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCount |=> toggleCount == '0);

  // R7
  count_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toggleCount == CNT_MAX && !strobe.clearCount) |=> toggleCount == CNT_MAX);

endmodule

// File: rtl/escape_ctrl.sv
module escape_ctrl
  import escape_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int LEN_W       = 6,
  parameter int ACT_COUNT   = 6,
  parameter int FORCE_COUNT = 8,
  parameter int ACT_LEN     = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkLevel,
  input  logic             clkRise,
  input  logic [CNT_W-1:0] toggleCount,
  output dpStrobe_t        strobe,
  output logic             activateStart,
  output logic             fourWireForce,
  output linkMode_e        linkMode,
  output logic [LEN_W-1:0] expectLen
);

  logic isAct, isForce;

  assign isAct   = (toggleCount == CNT_W'(ACT_COUNT));
  assign isForce = (toggleCount >= CNT_W'(FORCE_COUNT));

  always_comb begin
    strobe.clearCount = clkRise;
    strobe.countEn    = clkLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activateStart <= 1'b0;
      fourWireForce <= 1'b0;
      linkMode      <= MODE_FOUR_WIRE;
      expectLen     <= '0;
    end else begin
      activateStart <= 1'b0;
      fourWireForce <= 1'b0;
      if (clkRise) begin
        if (isAct) begin
          activateStart <= 1'b1;
          linkMode      <= MODE_ACTIVATING;
          expectLen     <= LEN_W'(ACT_LEN);
        end else if (isForce) begin
          fourWireForce <= 1'b1;
          linkMode      <= MODE_FOUR_WIRE;
          expectLen     <= '0;
        end
      end
    end
  end

  // R2
  act_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    activateStart |-> (linkMode == MODE_ACTIVATING));

  // R3
  force_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    fourWireForce |-> (linkMode == MODE_FOUR_WIRE && expectLen == '0));

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({activateStart, fourWireForce}));

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activateStart || fourWireForce) |=> !(activateStart || fourWireForce));

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkMode != $past(linkMode)) |-> (activateStart || fourWireForce));

endmodule

// File: rtl/escape_detector.sv
module escape_detector
  import escape_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int LEN_W       = 6,
  parameter int ACT_COUNT   = 6,
  parameter int FORCE_COUNT = 8,
  parameter int ACT_LEN     = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linkClk,
  input  logic             linkData,
  output logic             activateStart,
  output logic             fourWireForce,
  output logic             linkMode,
  output logic [LEN_W-1:0] expectLen
);

  dpStrobe_t        strobe;
  logic             clkLevel, clkRise;
  logic [CNT_W-1:0] toggleCount;
  linkMode_e        modeReg;

  escape_datapath #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .linkClk     (linkClk),
    .linkData    (linkData),
    .strobe      (strobe),
    .clkLevel    (clkLevel),
    .clkRise     (clkRise),
    .toggleCount (toggleCount)
  );

  escape_ctrl #(
    .CNT_W(CNT_W), .LEN_W(LEN_W), .ACT_COUNT(ACT_COUNT),
    .FORCE_COUNT(FORCE_COUNT), .ACT_LEN(ACT_LEN)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .clkLevel      (clkLevel),
    .clkRise       (clkRise),
    .toggleCount   (toggleCount),
    .strobe        (strobe),
    .activateStart (activateStart),
    .fourWireForce (fourWireForce),
    .linkMode      (modeReg),
    .expectLen     (expectLen)
  );

  assign linkMode = modeReg;

endmodule

// File: tb/escape_detector_bench.sv
`timescale 1ns/1ps
module escape_detector_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       linkClk = 1'b0;
  logic       linkData = 1'b0;
  logic       activateStart, fourWireForce, linkMode;
  logic [5:0] expectLen;

  int checks = 0;
  int fails = 0;
  int actSeen = 0;
  int forceSeen = 0;
  int actBase = 0;
  int forceBase = 0;

  always #2.5 clk = ~clk;

  escape_detector u_escape_detector (
    .clk           (clk),
    .rstN          (rstN),
    .linkClk       (linkClk),
    .linkData      (linkData),
    .activateStart (activateStart),
    .fourWireForce (fourWireForce),
    .linkMode      (linkMode),
    .expectLen     (expectLen)
  );

  // Count the system cycles each pulse is high.
  always @(posedge clk) begin
    if (rstN) begin
      if (activateStart) actSeen++;
      if (fourWireForce) forceSeen++;
    end
  end

  typedef struct packed {
    logic [4:0] toggles;
    logic       expAct;
    logic       expForce;
    logic       expMode;
    logic [5:0] expLen;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{5'd3, 1'b0, 1'b0, 1'b0, 6'd0},   // R4 below threshold
    '{5'd6, 1'b1, 1'b0, 1'b1, 6'd12},  // R2 activation
    '{5'd5, 1'b0, 1'b0, 1'b1, 6'd12},  // R4 hold activating
    '{5'd7, 1'b0, 1'b0, 1'b1, 6'd12},  // R4 seven ignored
    '{5'd8, 1'b0, 1'b1, 1'b0, 6'd0},   // R3 force
    '{5'd0, 1'b0, 1'b0, 1'b0, 6'd0},   // R4 zero
    '{5'd6, 1'b1, 1'b0, 1'b1, 6'd12},  // R2
    '{5'd6, 1'b1, 1'b0, 1'b1, 6'd12},  // R2 re-activation
    '{5'd9, 1'b0, 1'b1, 1'b0, 6'd0},   // R3
    '{5'd1, 1'b0, 1'b0, 1'b0, 6'd0},   // R4
    '{5'd8, 1'b0, 1'b1, 1'b0, 6'd0},   // R3 already four-wire
    '{5'd4, 1'b0, 1'b0, 1'b0, 6'd0}    // R4
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Link clock is high on entry; toggles while high, fall, optional low toggles, rise.
  task automatic runEscape(input int highN, input int lowN);
    for (int i = 0; i < highN; i++) begin
      linkData = ~linkData;
      hold(4);
    end
    linkClk = 1'b0;
    hold(4);
    for (int i = 0; i < lowN; i++) begin
      linkData = ~linkData;
      hold(4);
    end
    actBase = actSeen;
    forceBase = forceSeen;
    linkClk = 1'b1;
    hold(8);
  endtask

  task automatic checkEvent(input string req, input logic eAct, input logic eForce,
                            input logic eMode, input logic [5:0] eLen);
    check((actSeen - actBase) == int'(eAct), {req, " activateStart cycles"},
          actSeen - actBase, int'(eAct));
    check((forceSeen - forceBase) == int'(eForce), {req, " fourWireForce cycles"},
          forceSeen - forceBase, int'(eForce));
    check(linkMode == eMode && expectLen == eLen, {req, " mode/len"},
          {linkMode, expectLen}, {eMode, eLen});
  endtask

  initial begin
    hold(5);
    rstN = 1'b1;
    hold(2);
    // R1 reset state
    check(linkMode == 1'b0, "R1 linkMode", linkMode, 0);
    check(expectLen == 6'd0, "R1 expectLen", expectLen, 0);
    check(!activateStart && !fourWireForce, "R1 pulses",
          {activateStart, fourWireForce}, 0);

    actBase = actSeen;
    forceBase = forceSeen;
    linkClk = 1'b1;
    hold(8);
    checkEvent("R4 first rise", 1'b0, 1'b0, 1'b0, 6'd0);

    for (int v = 0; v < NVEC; v++) begin
      runEscape(int'(VECS[v].toggles), 0);
      checkEvent($sformatf("vector %0d (R2/R3/R4/R8)", v), VECS[v].expAct,
                 VECS[v].expForce, VECS[v].expMode, VECS[v].expLen);
    end

    // R5: six toggles while the link clock is low
    runEscape(0, 6);
    checkEvent("R5 low-phase toggles", 1'b0, 1'b0, 1'b0, 6'd0);

    // R6: three plus three across two high phases
    runEscape(3, 0);
    checkEvent("R6 first half", 1'b0, 1'b0, 1'b0, 6'd0);
    runEscape(3, 0);
    checkEvent("R6 second half", 1'b0, 1'b0, 1'b0, 6'd0);

    // R7: saturation, 22 toggles (would wrap to 6)
    runEscape(6, 0);
    checkEvent("R7 setup", 1'b1, 1'b0, 1'b1, 6'd12);
    runEscape(22, 0);
    checkEvent("R7 saturation", 1'b0, 1'b1, 1'b0, 6'd0);

    // R9 / R8: cycle-exact pulse timing
    for (int i = 0; i < 6; i++) begin
      linkData = ~linkData;
      hold(4);
    end
    linkClk = 1'b0;
    hold(4);
    linkClk = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    check(activateStart == 1'b0, "R9 not before third cycle", activateStart, 0);
    @(posedge clk);
    #1;
    check(activateStart == 1'b1, "R9 pulse in third cycle", activateStart, 1);
    check(linkMode == 1'b1, "R9 mode with pulse", linkMode, 1);
    @(posedge clk);
    #1;
    check(activateStart == 1'b0, "R8 one-cycle width", activateStart, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule